// File: doc/BRIEF.md
# MDIO Management Controller with Background PHY Scan

This block is a register-mapped management master for Clause-22 PHYs. It drives a management clock (MDC) and a bidirectional data line (output, output-enable and input), and it serializes 64-bit read and write frames. The management clock runs at the input clock divided by a programmable amount. Software sees a small register port. It writes one user-access register to start a transaction, then polls until that transaction completes.

While enabled, a scan engine keeps reading the status register of every PHY address in turn. It records in two 32-bit maps which addresses answered and which of them report link up. When software posts a user access, the access takes the bus as soon as the frame in flight ends. When the enable is cleared, the scan stops, and the controller reports idle once the wire is quiet.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The register port decodes word address 0 as version ({16'h0, major[15:8], minor[7:0]}), 1 as control, 2 as the answered map, 3 as the link map and 4 as user access. Any other address reads 0. After reset, control reads {idle=1 at bit 31, enable=0 at bit 30, DIV_RST at bits 7:0}, and user access, both maps, MDC and output-enable all read 0.
- R2: Control bit 30 is the enable and bits 7:0 are the divider D. While a frame runs, one MDC period lasts D+1 input clocks. The divider is taken at frame start.
- R3: A frame is 32 ones, then start 01, then the opcode (10 read, 01 write), the 5-bit PHY address, the 5-bit register address and a 2-bit turnaround (10 on writes), then 16 data bits, MSB first. Data changes while MDC is low.
- R4: In a read frame the master releases the data line from the first turnaround bit to the frame end. ACK (user bit 29) is set when the PHY drives the line low in the second turnaround bit, and the 16 sampled bits land in user bits 15:0.
- R5: The user-access layout is GO bit 31, WRITE bit 30 (0 = read), ACK bit 29, register address bits 25:21, PHY address bits 20:16 and data bits 15:0. A write with GO set posts an access and clears ACK. GO clears by itself when the frame ends. A write to user access while GO is set is ignored.
- R6: While the engine is enabled, the scan reads register 1 of PHY addresses 0 to 31 in round-robin order. Bit n of the answered map is set when PHY n acknowledged its latest poll. Link bit n equals that acknowledge ANDed with status bit 2.
- R7: A pending user access goes before the next scan frame. It waits at most for the one frame already in flight.
- R8: Clearing the enable stops new frames. Idle (control bit 31) is 0 while enable is set and rises once the frame in flight has ended. A user access posted while the enable is clear stays pending with GO set, and it runs once the enable is set.
- R9: With no frame in flight, MDC is low and the data output-enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line as seen on the wire |

## Verification
The hardest state to reach from the ports is a user access that collides with a scan frame already on the wire. The bench waits for a rising MDC edge while only the scan is running, then posts a read and bounds how long GO stays set. It also posts a second access while the first is pending, and it posts one while the engine is disabled, to show it is held. A behavioural PHY model decodes every frame from the wire, answers only at chosen addresses and flags contention on the data line. This lets the scan maps, the read data and the write contents all be predicted from the model's own register array.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int PHY_AW     = 5;
  localparam int NUM_PHY    = 1 << PHY_AW;
  localparam int DATA_W     = 16;
  localparam int STAT_REG   = 1;
  localparam int LINK_BIT   = 2;

  typedef struct packed {
    logic              wr;
    logic [PHY_AW-1:0] phy;
    logic [4:0]        regad;
    logic [DATA_W-1:0] data;
  } mdio_req_t;

  typedef enum logic [2:0] {
    SEL_VER   = 3'd0,
    SEL_CTRL  = 3'd1,
    SEL_ALIVE = 3'd2,
    SEL_LINK  = 3'd3,
    SEL_USER  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/mdio_bitclk.sv
module mdio_bitclk #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            mdc,
  output logic            smp,
  output logic            bend
);
  logic [DIVW-1:0] cnt_q, cnt_n;
  logic [DIVW:0]   half;

  assign half = ({1'b0, div} + 1'b1) >> 1;
  assign mdc  = run && ({1'b0, cnt_q} >= half);
  assign smp  = run && ({1'b0, cnt_q} == half);
  assign bend = run && (cnt_q == div);

  always_comb begin
    cnt_n = cnt_q;
    if (!run || bend) cnt_n = '0;
    else              cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_req_t         req,
  input  logic [DIVW-1:0]   div,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int IDXW = $clog2(FRAME_BITS);
  localparam logic [IDXW-1:0] TA1_IDX  = IDXW'(PRE_BITS + 14);
  localparam logic [IDXW-1:0] TA2_IDX  = IDXW'(PRE_BITS + 15);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FRAME_BITS - 1);

  logic                  busy_q, busy_n, done_q, done_n, rd_q, rd_n;
  logic                  ack_q, ack_n;
  logic [IDXW-1:0]       idx_q, idx_n;
  logic [FRAME_BITS-1:0] sh_q, sh_n, fr;
  logic [DIVW-1:0]       divl_q, divl_n;
  logic [DATA_W-1:0]     rdat_q, rdat_n;
  logic                  smp, bend;

  mdio_bitclk #(.DIVW(DIVW)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .div(divl_q),
    .mdc(mdc), .smp(smp), .bend(bend)
  );

  always_comb begin
    fr = {{PRE_BITS{1'b1}}, 2'b01, (req.wr ? 2'b01 : 2'b10), req.phy, req.regad,
          (req.wr ? 2'b10 : 2'b00), (req.wr ? req.data : {DATA_W{1'b0}})};
  end

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    rd_n   = rd_q;
    ack_n  = ack_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    divl_n = divl_q;
    rdat_n = rdat_q;
    if (start && !busy_q) begin
      busy_n = 1'b1;
      idx_n  = '0;
      sh_n   = fr;
      rd_n   = !req.wr;
      divl_n = div;
      ack_n  = 1'b0;
    end else if (busy_q) begin
      if (smp && rd_q) begin
        if (idx_q == TA2_IDX)     ack_n  = !mdio_i;
        else if (idx_q > TA2_IDX) rdat_n = {rdat_q[DATA_W-2:0], mdio_i};
      end
      if (bend) begin
        if (idx_q == LAST_IDX) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end else begin
          idx_n = idx_q + 1'b1;
          sh_n  = {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      ack_q  <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      divl_q <= '0;
      rdat_q <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      rd_q   <= rd_n;
      ack_q  <= ack_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      divl_q <= divl_n;
      rdat_q <= rdat_n;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign ack     = ack_q;
  assign rdata   = rdat_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && !(rd_q && (idx_q >= TA1_IDX));
endmodule

// File: rtl/mdio_scan_arb.sv
module mdio_scan_arb
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               user_go,
  input  mdio_req_t          user_req,
  input  logic               f_busy,
  input  logic               f_done,
  input  logic               f_ack,
  input  logic [DATA_W-1:0]  f_rdata,
  output logic               f_start,
  output mdio_req_t          f_req,
  output logic               user_done,
  output logic               scan_done,
  output logic [PHY_AW-1:0]  scan_addr,
  output logic [NUM_PHY-1:0] alive,
  output logic [NUM_PHY-1:0] link
);
  logic               owner_q, owner_n;
  logic [PHY_AW-1:0]  addr_q, addr_n;
  logic [NUM_PHY-1:0] alive_q, alive_n, link_q, link_n;
  logic               rdata_unused;

  assign rdata_unused = ^{f_rdata[DATA_W-1:LINK_BIT+1], f_rdata[LINK_BIT-1:0]};

  assign f_start   = en && !f_busy && !f_done;
  assign user_done = f_done && owner_q;
  assign scan_done = f_done && !owner_q;

  always_comb begin
    if (user_go) f_req = user_req;
    else         f_req = '{wr: 1'b0, phy: addr_q, regad: 5'(STAT_REG), data: '0};
  end

  always_comb begin
    owner_n = owner_q;
    addr_n  = addr_q;
    alive_n = alive_q;
    link_n  = link_q;
    if (f_start) owner_n = user_go;
    if (scan_done) begin
      alive_n[addr_q] = f_ack;
      link_n[addr_q]  = f_ack && f_rdata[LINK_BIT];
      addr_n          = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= 1'b0;
      addr_q  <= '0;
      alive_q <= '0;
      link_q  <= '0;
    end else begin
      owner_q <= owner_n;
      addr_q  <= addr_n;
      alive_q <= alive_n;
      link_q  <= link_n;
    end
  end

  assign scan_addr = addr_q;
  assign alive     = alive_q;
  assign link      = link_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter logic [7:0] DIV_RST   = 8'd9,
  parameter logic [7:0] VER_MAJOR = 8'd1,
  parameter logic [7:0] VER_MINOR = 8'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DIVW = $bits(DIV_RST);

  logic [1:0]  rst_sync_q;
  logic        rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic              en_q, en_n, go_q, go_n, ack_q, ack_n;
  logic [DIVW-1:0]   div_q, div_n;
  mdio_req_t         ureq_q, ureq_n, f_req;
  logic              f_start, f_busy, f_done, f_ack, user_done, scan_done, idle;
  logic [DATA_W-1:0] f_rdata;
  logic [PHY_AW-1:0] scan_addr;
  logic [NUM_PHY-1:0] alive, link;
  logic              wr_ctrl, wr_user, wdata_unused;

  assign wdata_unused = ^{reg_wdata[31], reg_wdata[29:26], reg_wdata[DIVW+21:DIVW]};

  assign wr_ctrl = reg_wr && (reg_addr == SEL_CTRL);
  assign wr_user = reg_wr && (reg_addr == SEL_USER) && !go_q;

  always_comb begin
    en_n   = en_q;
    div_n  = div_q;
    go_n   = go_q;
    ack_n  = ack_q;
    ureq_n = ureq_q;
    if (wr_ctrl) begin
      en_n  = reg_wdata[30];
      div_n = reg_wdata[DIVW-1:0];
    end
    if (wr_user) begin
      go_n   = reg_wdata[31];
      ureq_n = '{wr: reg_wdata[30], phy: reg_wdata[20:16], regad: reg_wdata[25:21],
                 data: reg_wdata[15:0]};
      if (reg_wdata[31]) ack_n = 1'b0;
    end
    if (user_done) begin
      go_n = 1'b0;
      if (!ureq_q.wr) begin
        ack_n       = f_ack;
        ureq_n.data = f_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_q   <= 1'b0;
      div_q  <= DIV_RST;
      go_q   <= 1'b0;
      ack_q  <= 1'b0;
      ureq_q <= '0;
    end else begin
      en_q   <= en_n;
      div_q  <= div_n;
      go_q   <= go_n;
      ack_q  <= ack_n;
      ureq_q <= ureq_n;
    end
  end

  mdio_scan_arb u_arb (
    .clk(clk), .rst_n(rst_n_s), .en(en_q), .user_go(go_q), .user_req(ureq_q),
    .f_busy(f_busy), .f_done(f_done), .f_ack(f_ack), .f_rdata(f_rdata),
    .f_start(f_start), .f_req(f_req), .user_done(user_done), .scan_done(scan_done),
    .scan_addr(scan_addr), .alive(alive), .link(link)
  );

  mdio_frame #(.DIVW(DIVW)) u_frame (
    .clk(clk), .rst_n(rst_n_s), .start(f_start), .req(f_req), .div(div_q),
    .mdio_i(mdio_i), .busy(f_busy), .done(f_done), .ack(f_ack), .rdata(f_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  assign idle = !en_q && !f_busy && !f_done;

  always_comb begin
    case (reg_addr)
      SEL_VER:   reg_rdata = {16'h0, VER_MAJOR, VER_MINOR};
      SEL_CTRL:  reg_rdata = {idle, en_q, {(30-DIVW){1'b0}}, div_q};
      SEL_ALIVE: reg_rdata = alive;
      SEL_LINK:  reg_rdata = link;
      SEL_USER:  reg_rdata = {go_q, ureq_q.wr, ack_q, 3'b000, ureq_q.regad,
                              ureq_q.phy, ureq_q.data};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_pkg::*;
(
  input logic               clk,
  input logic               rst_n_s,
  input logic               mdc,
  input logic               mdio_oe,
  input logic               f_busy,
  input logic               f_start,
  input logic               en_q,
  input logic               idle,
  input logic               go_q,
  input logic               user_done,
  input logic               scan_done,
  input logic [PHY_AW-1:0]  scan_addr,
  input logic [NUM_PHY-1:0] alive
);
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !f_busy |-> (!mdc && !mdio_oe));

  p_idle_excl_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    en_q |-> !idle);

  p_start_en_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    f_start |-> en_q);

  p_go_hold_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (go_q && !user_done) |=> go_q);

  p_go_clear_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    user_done |=> !go_q);

  p_scan_step_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    scan_done |=> (scan_addr == $past(scan_addr) + 1'b1));

  p_alive_one_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones(alive ^ $past(alive)) <= 1);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .mdc(mdc), .mdio_oe(mdio_oe), .f_busy(f_busy),
  .f_start(f_start), .en_q(en_q), .idle(idle), .go_q(go_q), .user_done(user_done),
  .scan_done(scan_done), .scan_addr(scan_addr), .alive(alive)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_line;
  logic        phy_drv = 1'b0, phy_val = 1'b1;

  int total = 0, bad = 0, contention = 0, fmt_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  mdio_mgmt_ctrl #(.DIV_RST(8'd3), .VER_MAJOR(8'd2), .VER_MINOR(8'd7)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  // behavioural PHY set: answers at addresses 0, 9, 17, 31
  logic [15:0] phy_mem [32][32];
  int ones = 0, pos = 0;
  bit inframe = 0;
  logic [31:0] sh = '0;
  logic [1:0]  rd_op = 2'b00;
  logic [4:0]  rd_pa = '0, rd_ra = '0;

  function automatic bit present(input int a);
    return (a == 0) || (a == 9) || (a == 17) || (a == 31);
  endfunction

  always @(posedge mdc) begin
    if (!inframe) begin
      if (mdio_line) ones++;
      else begin
        if (ones >= 32) begin inframe = 1; pos = 1; sh = '0; rd_op = 2'b00; end
        ones = 0;
      end
    end else begin
      sh = {sh[30:0], mdio_line};
      pos++;
      if (pos == 14) begin rd_op = sh[11:10]; rd_pa = sh[9:5]; rd_ra = sh[4:0]; end
      if (pos == 32) begin
        if (sh[30] != 1'b1) fmt_err++;
        if (sh[29:28] == 2'b01) begin
          if (sh[17:16] != 2'b10) fmt_err++;
          if (present(int'(sh[27:23]))) phy_mem[sh[27:23]][sh[22:18]] = sh[15:0];
        end else if (sh[29:28] != 2'b10) fmt_err++;
        inframe = 0; ones = 0;
      end
    end
  end

  always @(negedge mdc) begin
    if (inframe && rd_op == 2'b10 && present(int'(rd_pa)) && pos >= 15 && pos <= 31) begin
      phy_drv = 1'b1;
      phy_val = (pos == 15) ? 1'b0 : phy_mem[rd_pa][rd_ra][31-pos];
    end else phy_drv = 1'b0;
  end

  always @(posedge clk) if (mdio_oe && phy_drv) contention++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] uacc(input bit w, input int pa, input int ra, input logic [15:0] d);
    return {1'b1, w, 1'b0, 3'b000, 5'(ra), 5'(pa), d};
  endfunction

  task automatic wait_go(output int cyc);
    logic [31:0] v;
    cyc = 0;
    forever begin
      rd(3'd4, v);
      if (!v[31] || cyc > 3000) break;
      @(negedge clk); cyc++;
    end
  endtask

  task automatic wait_rise();
    while (mdc) @(negedge clk);
    while (!mdc) @(negedge clk);
  endtask

  task automatic period(output int n);
    wait_rise();
    n = 0;
    do begin @(negedge clk); n++; end while (mdc);
    do begin @(negedge clk); n++; end while (!mdc);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  initial begin
    logic [31:0] v;
    int cyc, p1, p2, p3, pmin, rises;
    logic [15:0] exp_d;
    for (int a = 0; a < 32; a++)
      for (int r = 0; r < 32; r++)
        phy_mem[a][r] = (r == 1) ? (16'h7809 | ((a == 0 || a == 17) ? 16'h4 : 16'h0)) : 16'h0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and map
    rd(3'd0, v); chk(v == 32'h0000_0207, "R1 version", v, 32'h0000_0207);
    rd(3'd1, v); chk(v == 32'h8000_0003, "R1 control reset", v, 32'h8000_0003);
    rd(3'd2, v); chk(v == 0, "R1 alive reset", v, 0);
    rd(3'd3, v); chk(v == 0, "R1 link reset", v, 0);
    rd(3'd4, v); chk(v == 0, "R1 user reset", v, 0);
    rd(3'd6, v); chk(v == 0, "R1 unmapped", v, 0);
    chk(!mdc && !mdio_oe, "R9 quiet after reset", {mdc, mdio_oe}, 0);

    // R8 access held while disabled
    wr(3'd4, uacc(0, 0, 1, 16'h0));
    rises = 0;
    repeat (600) begin @(negedge clk); if (mdc || mdio_oe) rises++; end
    chk(rises == 0, "R8 no wire activity while disabled", rises, 0);
    rd(3'd4, v); chk(v[31] == 1'b1, "R8 GO held while disabled", v, 32'h8000_0000);

    // R7 pending user access runs first once enabled
    wr(3'd1, 32'h4000_0003);
    wait_go(cyc);
    chk(cyc <= 262, "R7 user first after enable", cyc, 262);
    rd(3'd4, v);
    chk(v[29] && v[15:0] == 16'h780D, "R4 read ack and data phy0 reg1", v, {3'b001, 13'h0, 16'h780D});

    // R3 write, then read back
    wr(3'd4, uacc(1, 31, 30, 16'hA5C3));
    wait_go(cyc);
    chk(phy_mem[31][30] == 16'hA5C3, "R3 write frame stored", phy_mem[31][30], 16'hA5C3);
    rd(3'd4, v); chk(v[31] == 1'b0, "R5 GO self-clears after write", v, 0);
    wr(3'd4, uacc(0, 31, 30, 16'h0));
    wait_go(cyc);
    rd(3'd4, v); chk(v[29] && v[15:0] == 16'hA5C3, "R4 read back phy31 reg30", v, 32'h2000_A5C3);

    // R4 absent PHY gives no ACK
    wr(3'd4, uacc(0, 5, 3, 16'h0));
    wait_go(cyc);
    rd(3'd4, v); chk(v[31:29] == 3'b000, "R4 absent phy no ack", v[31:29], 0);

    // R3 R4 sweep over answering PHYs and several registers
    for (int pi = 0; pi < 4; pi++) begin
      int pa;
      pa = (pi == 0) ? 0 : (pi == 1) ? 9 : (pi == 2) ? 17 : 31;
      for (int r = 0; r < 32; r += 4) begin
        exp_d = 16'(pa * 16'h0111) ^ 16'(r * 16'h0F0F) ^ 16'h5A00;
        wr(3'd4, uacc(1, pa, r, exp_d));
        wait_go(cyc);
        wr(3'd4, uacc(0, pa, r, 16'h0));
        wait_go(cyc);
        rd(3'd4, v);
        chk(v[31:29] == 3'b001 && v[15:0] == exp_d && v[20:16] == 5'(pa) && v[25:21] == 5'(r),
            "R3 sweep write/read", v, {3'b001, 3'b000, 5'(r), 5'(pa), exp_d});
      end
    end

    // R6 full scan maps
    repeat (34 * 260) @(negedge clk);
    rd(3'd2, v); chk(v == 32'h8002_0201, "R6 alive map", v, 32'h8002_0201);
    rd(3'd3, v); chk(v == 32'h0002_0001, "R6 link map", v, 32'h0002_0001);

    // R6 link follows status bit 2
    wr(3'd4, uacc(1, 9, 1, 16'h780D));
    wait_go(cyc);
    wr(3'd4, uacc(1, 0, 1, 16'h7809));
    wait_go(cyc);
    repeat (34 * 260) @(negedge clk);
    rd(3'd3, v); chk(v == 32'h0002_0200, "R6 link map after change", v, 32'h0002_0200);

    // R5 ACK cleared on new access and writes ignored while GO
    wr(3'd4, uacc(0, 9, 8, 16'h0));
    rd(3'd4, v); chk(v[31:29] == 3'b100, "R5 ack cleared at new access", v[31:29], 3'b100);
    wr(3'd4, uacc(0, 17, 12, 16'h0));
    wait_go(cyc);
    rd(3'd4, v);
    chk(v[20:16] == 5'd9 && v[25:21] == 5'd8 && v[15:0] == phy_mem[9][8],
        "R5 write ignored while GO set", v, {11'h100, 5'd8, 5'd9, phy_mem[9][8]});

    // R7 deferral bound when colliding with a scan frame
    wait_rise();
    wr(3'd4, uacc(0, 17, 4, 16'h0));
    wait_go(cyc);
    chk(cyc >= 255 && cyc <= 530, "R7 deferred at most one frame", cyc, 530);

    // R2 divider sets MDC period
    period(p1); period(p2); period(p3);
    pmin = (p1 < p2) ? p1 : p2; pmin = (p3 < pmin) ? p3 : pmin;
    chk(pmin == 4, "R2 period div3", pmin, 4);
    wr(3'd1, 32'h4000_0001);
    repeat (600) @(negedge clk);
    period(p1); period(p2); period(p3);
    pmin = (p1 < p2) ? p1 : p2; pmin = (p3 < pmin) ? p3 : pmin;
    chk(pmin == 2, "R2 period div1", pmin, 2);
    rd(3'd1, v); chk(v == 32'h4000_0001, "R2 control readback", v, 32'h4000_0001);
    wr(3'd1, 32'h4000_0003);
    repeat (300) @(negedge clk);

    // R8 disable mid-frame
    wait_rise();
    wr(3'd1, 32'h0000_0003);
    rd(3'd1, v); chk(v[31] == 1'b0, "R8 idle low while frame drains", v, 32'h0000_0003);
    cyc = 0;
    forever begin rd(3'd1, v); if (v[31] || cyc > 3000) break; @(negedge clk); cyc++; end
    chk(cyc <= 260, "R8 idle after frame ends", cyc, 260);
    rises = 0;
    repeat (600) begin @(negedge clk); if (mdc || mdio_oe) rises++; end
    chk(rises == 0, "R9 wire quiet once idle", rises, 0);

    chk(fmt_err == 0, "R3 frame format at PHY", fmt_err, 0);
    chk(contention == 0, "R4 line released on reads", contention, 0);
    summary();
  end
endmodule